// File: doc/BRIEF.md
# Programmable Pixel Component Extractor

This block sits between a framebuffer fetch path and a display output stage. It takes one raw pixel word of one to four bytes per cycle and turns it into 8-bit red, green and blue components. Software sets each channel's position inside the pixel (lowest bit and bit count) and a fallback colour. It also sets the pixel width and byte order. This lets one datapath serve many packed pixel formats.

The fallback colour takes over for a channel in three cases: the channel has no bits configured, the pixel lies outside the visible area, or the fetch path reports an underrun. Setting a fallback of 0xFF on red and 0x00 on the other channels makes starved pixels show up as solid red. Results appear on registered outputs one clock after the pixel is presented.

Top module: `pxl_component_extract`

## Requirements
- R1: Configuration is written through `cfg_we`/`cfg_addr`/`cfg_wdata` and takes effect for pixels presented from the next cycle. Address 1 selects red, 2 selects green and 3 selects blue. In a channel word, bits [23:16] hold the fallback value, bits [11:8] the bit count and bits [4:0] the lowest bit index. All other bits are ignored.
- R2: Address 0 holds the pixel format. Bits [4:3] give bytes per pixel minus one, so 0 means one byte and 3 means four. Bit 31 selects byte order: 0 for little-endian, 1 for big-endian.
- R3: A channel takes `count` bits of the byte-ordered pixel, starting at its lowest bit index. Window bits past bit 31 read as zero.
- R4: When fewer than 8 bits are taken, they are placed at the top of the output and repeated from their MSB downward to fill the low bits, so an all-ones field gives 0xFF. When more than 8 bits are taken, the 8 most significant bits of the field are kept.
- R5: A channel whose bit count is zero outputs its fallback value.
- R6: When `pix_active` is low, every channel outputs its fallback value.
- R7: When `pix_underrun` is high, every channel outputs its fallback value. This holds even in the visible area.
- R8: Bytes of `pix_word` above the configured pixel width have no effect on any output.
- R9: In big-endian mode the bytes within the configured width are reversed before extraction. For example, with two bytes, byte 0 and byte 1 swap.
- R10: `rgb_valid_o` equals `pix_valid` delayed by one clock. RGB outputs update one clock after a valid pixel and hold their values after a cycle with `pix_valid` low.
- R11: After reset, all outputs and all configuration are zero, so valid pixels produce 0 on every channel until the block is configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select (0 format, 1 red, 2 green, 3 blue) |
| cfg_wdata | input | 32 | Configuration write data |
| pix_word | input | 32 | Raw pixel word, byte 0 in bits [7:0] |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_active | input | 1 | Pixel lies inside the visible area |
| pix_underrun | input | 1 | Fetch path could not supply this pixel |
| red_o | output | 8 | Red component |
| green_o | output | 8 | Green component |
| blue_o | output | 8 | Blue component |
| rgb_valid_o | output | 1 | Components valid, one clock after `pix_valid` |

## Verification
Extraction is tried with several directed patterns:
- 16-bit 5-6-5 words with single saturated channels, which separate the channel windows from one another.
- Half-scale words, which expose the bit replication of short fields.
- Extra bytes above the pixel width and swapped-order words, which tell the width mask and the byte reversal apart.

Directed fields longer than 8 bits and windows running past bit 31 probe truncation and zero fill. Fallback substitution is checked separately for a zero count, outside the visible area and during an underrun. Long runs then mix random formats, field placements and control flags, including idle cycles that must leave the outputs unchanged.

// File: rtl/pxl_extract_pkg.sv
package pxl_extract_pkg;
  localparam int PIX_BYTES = 4;
  localparam int PIX_W     = PIX_BYTES * 8;
  localparam int COMP_W    = 8;
  localparam int LEN_W     = 4;
  localparam int LSB_W     = 5;
  localparam int NUM_CH    = 3;
  localparam int BSEL_W    = $clog2(PIX_BYTES);

  typedef struct packed {
    logic [COMP_W-1:0] dflt;
    logic [LEN_W-1:0]  len;
    logic [LSB_W-1:0]  lsb;
  } chan_cfg_t;

  typedef struct packed {
    logic              big_end;
    logic [BSEL_W-1:0] bytes_m1;
  } fmt_cfg_t;

  // Channel word: fallback [23:16], count [11:8], lowest bit [4:0]
  function automatic chan_cfg_t decode_sel(input logic [31:0] w);
    chan_cfg_t c;
    c.dflt = w[23:16];
    c.len  = w[11:8];
    c.lsb  = w[4:0];
    return c;
  endfunction

  // Format word: byte order [31], bytes minus one [4:3]
  function automatic fmt_cfg_t decode_fmt(input logic [31:0] w);
    fmt_cfg_t f;
    f.big_end  = w[31];
    f.bytes_m1 = w[4:3];
    return f;
  endfunction

  // Keep only the configured bytes, reversing them in big-endian mode
  function automatic logic [PIX_W-1:0] order_bytes(input logic [PIX_W-1:0] word,
                                                   input fmt_cfg_t f);
    logic [PIX_W-1:0] res;
    logic [PIX_W-1:0] tmp;
    int nb;
    int src;
    res = '0;
    nb  = int'(f.bytes_m1) + 1;
    for (int k = 0; k < PIX_BYTES; k++) begin
      if (k < nb) begin
        src = f.big_end ? (nb - 1 - k) : k;
        tmp = word >> (8 * src);
        res = res | ({{(PIX_W-8){1'b0}}, tmp[7:0]} << (8 * k));
      end
    end
    return res;
  endfunction

  // Scale a field of len bits (at the bottom of win) to COMP_W bits
  function automatic logic [COMP_W-1:0] scale_comp(input logic [PIX_W-1:0] win,
                                                   input logic [LEN_W-1:0] len);
    logic [COMP_W-1:0] res;
    int n;
    int idx;
    res = '0;
    n   = int'(len);
    if (n != 0) begin
      for (int i = 0; i < COMP_W; i++) begin
        if (n >= COMP_W) idx = n - 1 - i;
        else             idx = n - 1 - (i % n);
        res[COMP_W-1-i] = win[idx[LSB_W-1:0]];
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/pxl_cfg_regs.sv
module pxl_cfg_regs
  import pxl_extract_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [1:0]             addr,
  input  logic [31:0]            wdata,
  output fmt_cfg_t               fmt_o,
  output chan_cfg_t [NUM_CH-1:0] sel_o
);
  fmt_cfg_t               fmt_q;
  chan_cfg_t [NUM_CH-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= '0;
      sel_q <= '0;
    end else if (we) begin
      case (addr)
        2'd0:    fmt_q    <= decode_fmt(wdata);
        2'd1:    sel_q[0] <= decode_sel(wdata);
        2'd2:    sel_q[1] <= decode_sel(wdata);
        default: sel_q[2] <= decode_sel(wdata);
      endcase
    end
  end

  assign fmt_o = fmt_q;
  assign sel_o = sel_q;

  assert_red_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd1) |=> (sel_o[0] == decode_sel($past(wdata))));

  assert_fmt_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd0) |=> (fmt_o == decode_fmt($past(wdata))));

  assert_fmt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == 2'd0) |=> $stable(fmt_o));
endmodule

// File: rtl/pxl_byte_order.sv
module pxl_byte_order
  import pxl_extract_pkg::*;
(
  input  logic [PIX_W-1:0] word_i,
  input  fmt_cfg_t         fmt_i,
  output logic [PIX_W-1:0] norm_o
);
  always_comb norm_o = order_bytes(word_i, fmt_i);
endmodule

// File: rtl/pxl_chan_slice.sv
module pxl_chan_slice
  import pxl_extract_pkg::*;
(
  input  logic [PIX_W-1:0]  norm_i,
  input  chan_cfg_t         cfg_i,
  input  logic              active_i,
  input  logic              underrun_i,
  output logic              use_dflt_o,
  output logic [COMP_W-1:0] comp_o
);
  logic [PIX_W-1:0]  window;
  logic [COMP_W-1:0] scaled;

  assign window     = norm_i >> cfg_i.lsb;
  assign scaled     = scale_comp(window, cfg_i.len);
  assign use_dflt_o = (cfg_i.len == '0) || !active_i || underrun_i;
  assign comp_o     = use_dflt_o ? cfg_i.dflt : scaled;
endmodule

// File: rtl/pxl_component_extract.sv
module pxl_component_extract
  import pxl_extract_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [PIX_W-1:0]  pix_word,
  input  logic              pix_valid,
  input  logic              pix_active,
  input  logic              pix_underrun,
  output logic [COMP_W-1:0] red_o,
  output logic [COMP_W-1:0] green_o,
  output logic [COMP_W-1:0] blue_o,
  output logic              rgb_valid_o
);
  fmt_cfg_t                         fmt;
  chan_cfg_t [NUM_CH-1:0]           sel;
  logic [PIX_W-1:0]                 norm_word;
  logic [NUM_CH-1:0][COMP_W-1:0]    comp_next;
  logic [NUM_CH-1:0]                chan_dflt;
  logic [NUM_CH-1:0][COMP_W-1:0]    comp_q;
  logic                             valid_q;

  pxl_cfg_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .fmt_o (fmt),
    .sel_o (sel)
  );

  pxl_byte_order u_order (
    .word_i (pix_word),
    .fmt_i  (fmt),
    .norm_o (norm_word)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pxl_chan_slice u_slice (
      .norm_i     (norm_word),
      .cfg_i      (sel[c]),
      .active_i   (pix_active),
      .underrun_i (pix_underrun),
      .use_dflt_o (chan_dflt[c]),
      .comp_o     (comp_next[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         comp_q[c] <= '0;
      else if (pix_valid) comp_q[c] <= comp_next[c];
    end

    assert_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && sel[c].len == '0) |=> (comp_q[c] == $past(sel[c].dflt)));

    assert_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_active) |=> (comp_q[c] == $past(sel[c].dflt)));

    assert_underrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_underrun) |=> (comp_q[c] == $past(sel[c].dflt)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> $stable(comp_q[c]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= pix_valid;
  end

  assign red_o       = comp_q[0];
  assign green_o     = comp_q[1];
  assign blue_o      = comp_q[2];
  assign rgb_valid_o = valid_q;

  assert_valid_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> rgb_valid_o);

  assert_idle_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !rgb_valid_o);
endmodule

// File: tb/pxl_component_extract_bench.sv
module pxl_component_extract_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] pix_word = '0;
  logic        pix_valid = 1'b0;
  logic        pix_active = 1'b0;
  logic        pix_underrun = 1'b0;
  logic [7:0]  red_o, green_o, blue_o;
  logic        rgb_valid_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // bench copy of configuration
  int m_bytes = 1;
  bit m_big = 0;
  int m_dflt[3];
  int m_len[3];
  int m_lsb[3];
  logic [7:0] last_exp[3];

  always #10 clk = ~clk;

  pxl_component_extract u_pxl_component_extract (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_word(pix_word), .pix_valid(pix_valid),
    .pix_active(pix_active), .pix_underrun(pix_underrun),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o), .rgb_valid_o(rgb_valid_o)
  );

  function automatic logic [31:0] ref_norm(input logic [31:0] w);
    logic [31:0] r = '0;
    for (int k = 0; k < m_bytes; k++) begin
      logic [7:0] b;
      int src = m_big ? (m_bytes - 1 - k) : k;
      b = 8'((w >> (8 * src)) & 32'hFF);
      r[8*k +: 8] = b;
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_chan(input logic [31:0] norm, input int ch,
                                          input bit act, input bit und);
    logic [63:0] v, acc;
    int len = m_len[ch];
    int filled = 0;
    if (!act || und || len == 0) return 8'(m_dflt[ch]);
    v = ({32'h0, norm} >> m_lsb[ch]) & ((64'h1 << len) - 64'h1);
    if (len >= 8) return 8'(v >> (len - 8));
    acc = '0;
    while (filled < 8) begin
      acc = (acc << len) | v;
      filled += len;
    end
    return 8'(acc >> (filled - 8));
  endfunction

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_fmt(input int bytes, input bit big, input logic [31:0] junk);
    m_bytes = bytes; m_big = big;
    cfg_write(2'd0, (junk & 32'h7FFF_FFE7) | (32'(big) << 31) | (32'(bytes - 1) << 3));
  endtask

  task automatic set_sel(input int ch, input int dflt, input int len, input int lsb,
                         input logic [31:0] junk);
    m_dflt[ch] = dflt; m_len[ch] = len; m_lsb[ch] = lsb;
    cfg_write(2'(ch + 1), (junk & 32'hFF00_F0E0) | (32'(dflt) << 16) |
              (32'(len) << 8) | 32'(lsb));
  endtask

  task automatic check(input string tag, input logic [7:0] er, eg, eb, input logic ev);
    n_checks++;
    if (red_o !== er || green_o !== eg || blue_o !== eb || rgb_valid_o !== ev) begin
      n_fail++;
      $display("FAIL %s: got r=%h g=%h b=%h v=%b expected r=%h g=%h b=%h v=%b",
               tag, red_o, green_o, blue_o, rgb_valid_o, er, eg, eb, ev);
    end
  endtask

  task automatic send(input string tag, input logic [31:0] w, input bit vld,
                      input bit act, input bit und);
    logic [31:0] n;
    @(negedge clk);
    pix_word = w; pix_valid = vld; pix_active = act; pix_underrun = und;
    n = ref_norm(w);
    if (vld) for (int c = 0; c < 3; c++) last_exp[c] = ref_chan(n, c, act, und);
    @(negedge clk);
    pix_valid = 1'b0;
    check(tag, last_exp[0], last_exp[1], last_exp[2], vld);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 3; c++) begin
      m_dflt[c] = 0; m_len[c] = 0; m_lsb[c] = 0; last_exp[c] = '0;
    end
    repeat (3) @(negedge clk);
    check("R11 reset outputs", 8'h00, 8'h00, 8'h00, 1'b0);
    rst_n = 1'b1;
    send("R11 unconfigured pixel", 32'hDEAD_BEEF, 1, 1, 0);

    // 5-6-5 little-endian
    set_fmt(2, 0, 32'h0);
    set_sel(0, 8'hFF, 5, 11, 32'h0);
    set_sel(1, 8'h00, 6, 5, 32'h0);
    set_sel(2, 8'h00, 5, 0, 32'h0);
    send("R1 R3 red saturated", 32'h0000_F800, 1, 1, 0);
    send("R3 green saturated", 32'h0000_07E0, 1, 1, 0);
    send("R4 half scale replicate", 32'h0000_8410, 1, 1, 0);
    if (red_o !== 8'h84) begin n_fail++; $display("FAIL R4: got %h expected 84", red_o); end
    n_checks++;
    send("R8 upper bytes ignored", 32'hABCD_001F, 1, 1, 0);
    send("R7 underrun red", 32'h0000_07FF, 1, 1, 1);
    send("R6 outside active", 32'h0000_FFFF, 1, 0, 0);
    send("R10 idle hold", 32'h0000_0000, 0, 1, 0);
    set_fmt(2, 1, 32'h0);
    send("R9 big-endian two bytes", 32'h0000_00F8, 1, 1, 0);
    set_sel(1, 8'h5A, 0, 5, 32'h0);
    send("R5 zero count fallback", 32'h0000_FFFF, 1, 1, 0);

    // wide fields and window edge
    set_fmt(4, 1, 32'h0);
    set_sel(0, 8'h11, 12, 4, 32'h0);
    set_sel(1, 8'h22, 4, 30, 32'h0);
    set_sel(2, 8'h33, 8, 24, 32'h0);
    send("R4 long field truncation", 32'h1234_5678, 1, 1, 0);
    send("R3 window past bit 31", 32'hC3A5_5A3C, 1, 1, 0);
    set_fmt(3, 0, 32'h0);
    send("R8 R2 three-byte width", 32'hFF12_3456, 1, 1, 0);
    set_fmt(3, 1, 32'h0);
    send("R9 three-byte reversal", 32'hFF12_3456, 1, 1, 0);

    // random mix
    for (int it = 0; it < 600; it++) begin
      if (it % 25 == 0) begin
        set_fmt(int'($urandom_range(1, 4)), bit'($urandom_range(0, 1)), $urandom);
        for (int c = 0; c < 3; c++)
          set_sel(c, int'($urandom_range(0, 255)), int'($urandom_range(0, 15)),
                  int'($urandom_range(0, 31)), $urandom);
      end
      send("R1 R3 R4 random", $urandom, bit'($urandom_range(0, 7) != 0),
           bit'($urandom_range(0, 5) != 0), bit'($urandom_range(0, 9) == 0));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule